// File: doc/BRIEF.md
# SPI Queue Interrupt and Abort Control

This block holds the interrupt and error state of a queued SPI controller. It keeps three sticky status flags: a RAM write collision against the command being executed, an abort of a running queue by software, and completion of the queue. Each flag has its own interrupt enable. The block also holds two access-error enables and an abort lock-out bit, and it owns the SPI enable bit that starts and stops the queue.

Software reaches two registers over a simple register bus. Address 0 holds the enables and the flags, with write-one-to-clear flag bits. Address 1 holds the enable bit. The transfer engine reports each command completion along with the current queue index, the end pointer, a halt request and the wraparound mode. From these the block sets the finished flag and, where the queue really stops, clears the enable bit itself. A software clear of the enable bit during a transfer is either accepted, which sets the abort flag, or refused by lock-out. In both cases an access error can be signalled in the same cycle as the write.

Top module: `spiq_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0, `irq_o` and `spe_o` are 0, and no access error is signalled.
- R2: Register 0 bit map: 15 collision error enable, 14 abort error enable, 12 lock-out, 11 collision interrupt enable, 10 abort interrupt enable, 8 finished interrupt enable, 3 collision flag, 2 abort flag, 0 finished flag. Bits 13, 9, 7 to 4 and 1 read 0. Register 1 bit 0 is the enable bit and its other bits read 0.
- R3: Writing 1 to a flag bit of register 0 clears that flag on the next cycle. Writing 0 leaves the flag unchanged.
- R4: `irq_o` is 1 exactly when some flag is set together with its own interrupt enable.
- R5: A write of 0 to register 1 while `spe_o` and `xfer_active_i` are both 1 and lock-out is 0 clears the enable bit and sets the abort flag. `bus_err_o` is 1 in that write cycle if and only if the abort error enable is 1.
- R6: With lock-out set, that same write leaves `spe_o` at 1 and does not set the abort flag. `bus_err_o` is 1 if and only if the abort error enable is 1. Only a queue completion then clears the enable bit.
- R7: A command completion (`cmd_done_i`) while `spe_o` is 1, with `cur_idx_i` equal to `end_ptr_i`, sets the finished flag. Without wraparound it also clears `spe_o`. A completion at another index does neither, and a completion while `spe_o` is 0 is ignored.
- R8: A command completion while `spe_o` and `halt_req_i` are 1 sets the finished flag and clears `spe_o`, at any index.
- R9: In wraparound mode, an end-pointer completion sets the finished flag and leaves `spe_o` at 1.
- R10: A pulse on `collision_i` sets the collision flag. `bus_err_o` is 1 in that cycle if and only if the collision error enable is 1.
- R11: When a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.
- R12: A write of 0 to register 1 while no transfer is active clears `spe_o`, with no abort flag and no access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 control/flags, 1 enable |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected register |
| bus_err_o | output | 1 | Access error for the current access |
| collision_i | input | 1 | RAM write hit the executing command entry |
| xfer_active_i | input | 1 | Queue transfer in progress |
| cmd_done_i | input | 1 | A command finished this cycle |
| cur_idx_i | input | IDX_W | Index of the command that finished |
| end_ptr_i | input | IDX_W | Queue end pointer |
| halt_req_i | input | 1 | Halt requested |
| wrap_en_i | input | 1 | Wraparound mode |
| spe_o | output | 1 | SPI enable bit |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several properties. An access error must have a collision or an in-transfer clear of the enable bit as its cause. A lock-out must keep the enable bit set. An accepted clear must raise the abort flag. An end-pointer completion must set the finished flag, and in wraparound mode it must keep the enable bit. A collision must win against a same-cycle clear. The bench scenarios show the rest: the exact read-back layout and its reserved zeros, the write-one-to-clear behaviour with zero writes, interrupt masking per flag, halt completions at non-end indices, and completions that are ignored while the block is disabled.

// File: rtl/spiq_irq_pkg.sv
package spiq_irq_pkg;
  localparam int REG_W  = 16;
  localparam int N_FLAG = 3;

  // control field positions in register 0
  localparam int B_CERR_EN = 15;
  localparam int B_AERR_EN = 14;
  localparam int B_LOCK    = 12;
  localparam int B_CIE     = 11;
  localparam int B_AIE     = 10;
  localparam int B_FIE     = 8;

  typedef enum int {FL_COLL = 0, FL_ABRT = 1, FL_FIN = 2} flag_e;

  typedef struct packed {
    logic cerr_en;
    logic aerr_en;
    logic lock;
    logic cie;
    logic aie;
    logic fie;
  } ctl_t;

  // bit position of each flag in register 0
  function automatic int flag_pos(int idx);
    case (idx)
      FL_COLL: return 3;
      FL_ABRT: return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/spiq_flag_cell.sv
module spiq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/spiq_fin_detect.sv
module spiq_fin_detect #(
  parameter int IDX_W = 4
) (
  input  logic             cmd_done_i,
  input  logic             spe_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [IDX_W-1:0] end_ptr_i,
  input  logic             halt_i,
  input  logic             wrap_i,
  output logic             fin_o,
  output logic             hw_clr_o
);
  logic live, at_end;

  assign live     = cmd_done_i & spe_i;
  assign at_end   = (cur_idx_i == end_ptr_i);
  assign fin_o    = live & (at_end | halt_i);
  assign hw_clr_o = live & (halt_i | (at_end & ~wrap_i));
endmodule

// File: rtl/spiq_spe_ctrl.sv
module spiq_spe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic xfer_active_i,
  input  logic lock_i,
  input  logic aerr_en_i,
  input  logic hw_clr_i,
  output logic spe_o,
  output logic abort_o,
  output logic acc_err_o
);
  logic clr_req, blocked;

  assign clr_req   = wr_i & ~wbit_i & spe_o & xfer_active_i;
  assign blocked   = clr_req & lock_i;
  assign abort_o   = clr_req & ~lock_i;
  assign acc_err_o = clr_req & aerr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               spe_o <= 1'b0;
    else if (wr_i && !blocked) spe_o <= wbit_i;
    else if (hw_clr_i)         spe_o <= 1'b0;
  end
endmodule

// File: rtl/spiq_irq_ctrl.sv
module spiq_irq_ctrl
  import spiq_irq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic             bus_err_o,
  input  logic             collision_i,
  input  logic             xfer_active_i,
  input  logic             cmd_done_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [IDX_W-1:0] end_ptr_i,
  input  logic             halt_req_i,
  input  logic             wrap_en_i,
  output logic             spe_o,
  output logic             irq_o
);
  ctl_t              ctl_q;
  logic              wr_ctl, wr_spe;
  logic              fin_evt, hw_clr, abort_evt, spe_err;
  logic [N_FLAG-1:0] flag_set, flag_clr, flag_q, ie_vec;

  assign wr_ctl = bus_wr_i & ~bus_addr_i;
  assign wr_spe = bus_wr_i &  bus_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (wr_ctl) begin
      ctl_q.cerr_en <= bus_wdata_i[B_CERR_EN];
      ctl_q.aerr_en <= bus_wdata_i[B_AERR_EN];
      ctl_q.lock    <= bus_wdata_i[B_LOCK];
      ctl_q.cie     <= bus_wdata_i[B_CIE];
      ctl_q.aie     <= bus_wdata_i[B_AIE];
      ctl_q.fie     <= bus_wdata_i[B_FIE];
    end
  end

  spiq_fin_detect #(.IDX_W(IDX_W)) u_fin (
    .cmd_done_i (cmd_done_i),
    .spe_i      (spe_o),
    .cur_idx_i  (cur_idx_i),
    .end_ptr_i  (end_ptr_i),
    .halt_i     (halt_req_i),
    .wrap_i     (wrap_en_i),
    .fin_o      (fin_evt),
    .hw_clr_o   (hw_clr)
  );

  spiq_spe_ctrl u_spe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_spe),
    .wbit_i        (bus_wdata_i[0]),
    .xfer_active_i (xfer_active_i),
    .lock_i        (ctl_q.lock),
    .aerr_en_i     (ctl_q.aerr_en),
    .hw_clr_i      (hw_clr),
    .spe_o         (spe_o),
    .abort_o       (abort_evt),
    .acc_err_o     (spe_err)
  );

  assign flag_set[FL_COLL] = collision_i;
  assign flag_set[FL_ABRT] = abort_evt;
  assign flag_set[FL_FIN]  = fin_evt;

  assign ie_vec[FL_COLL] = ctl_q.cie;
  assign ie_vec[FL_ABRT] = ctl_q.aie;
  assign ie_vec[FL_FIN]  = ctl_q.fie;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    assign flag_clr[i] = wr_ctl & bus_wdata_i[flag_pos(i)];
    spiq_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[i]),
      .clr_i  (flag_clr[i]),
      .q_o    (flag_q[i])
    );
  end

  assign irq_o     = |(flag_q & ie_vec);
  assign bus_err_o = (collision_i & ctl_q.cerr_en) | spe_err;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i) begin
      bus_rdata_o[0] = spe_o;
    end else begin
      bus_rdata_o[B_CERR_EN] = ctl_q.cerr_en;
      bus_rdata_o[B_AERR_EN] = ctl_q.aerr_en;
      bus_rdata_o[B_LOCK]    = ctl_q.lock;
      bus_rdata_o[B_CIE]     = ctl_q.cie;
      bus_rdata_o[B_AIE]     = ctl_q.aie;
      bus_rdata_o[B_FIE]     = ctl_q.fie;
      for (int i = 0; i < N_FLAG; i++) bus_rdata_o[flag_pos(i)] = flag_q[i];
    end
  end
endmodule

// File: rtl/spiq_irq_ctrl_chk.sv
module spiq_irq_ctrl_chk
  import spiq_irq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_wr_i,
  input logic             bus_addr_i,
  input logic [REG_W-1:0] bus_wdata_i,
  input logic             bus_err_o,
  input logic             collision_i,
  input logic             xfer_active_i,
  input logic             cmd_done_i,
  input logic [IDX_W-1:0] cur_idx_i,
  input logic [IDX_W-1:0] end_ptr_i,
  input logic             halt_req_i,
  input logic             wrap_en_i,
  input logic             spe_o,
  input logic             irq_o,
  input logic [N_FLAG-1:0] flag_q,
  input ctl_t             ctl_q
);
  logic spe_clr_try;
  assign spe_clr_try = bus_wr_i & bus_addr_i & ~bus_wdata_i[0] & spe_o & xfer_active_i;

  p_abort_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spe_clr_try && !ctl_q.lock |=> flag_q[FL_ABRT] && !spe_o);

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spe_clr_try && ctl_q.lock && !cmd_done_i |=> spe_o);

  p_end_fin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i && spe_o && (cur_idx_i == end_ptr_i) |=> flag_q[FL_FIN]);

  p_wrap_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i && spe_o && wrap_en_i && !halt_req_i && (cur_idx_i == end_ptr_i)
    && !(bus_wr_i && bus_addr_i) |=> spe_o);

  p_coll_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_i |=> flag_q[FL_COLL]);

  p_err_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (collision_i || spe_clr_try));

  p_irq_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q != '0));
endmodule

bind spiq_irq_ctrl spiq_irq_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_err_o     (bus_err_o),
  .collision_i   (collision_i),
  .xfer_active_i (xfer_active_i),
  .cmd_done_i    (cmd_done_i),
  .cur_idx_i     (cur_idx_i),
  .end_ptr_i     (end_ptr_i),
  .halt_req_i    (halt_req_i),
  .wrap_en_i     (wrap_en_i),
  .spe_o         (spe_o),
  .irq_o         (irq_o),
  .flag_q        (flag_q),
  .ctl_q         (ctl_q)
);

// File: tb/spiq_irq_ctrl_bench.sv
module spiq_irq_ctrl_bench;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bus_wr_i = 1'b0;
  logic             bus_addr_i = 1'b0;
  logic [15:0]      bus_wdata_i = '0;
  logic [15:0]      bus_rdata_o;
  logic             bus_err_o;
  logic             collision_i = 1'b0;
  logic             xfer_active_i = 1'b0;
  logic             cmd_done_i = 1'b0;
  logic [IDX_W-1:0] cur_idx_i = '0;
  logic [IDX_W-1:0] end_ptr_i = '0;
  logic             halt_req_i = 1'b0;
  logic             wrap_en_i = 1'b0;
  logic             spe_o;
  logic             irq_o;

  always #2 clk = ~clk;  // 250 MHz

  spiq_irq_ctrl #(.IDX_W(IDX_W)) u_spiq_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bus_err_o(bus_err_o),
    .collision_i(collision_i), .xfer_active_i(xfer_active_i), .cmd_done_i(cmd_done_i),
    .cur_idx_i(cur_idx_i), .end_ptr_i(end_ptr_i), .halt_req_i(halt_req_i),
    .wrap_en_i(wrap_en_i), .spe_o(spe_o), .irq_o(irq_o)
  );

  typedef enum int {K_RD, K_IRQ, K_ERR, K_SPE} kind_e;
  typedef struct {
    kind_e       kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata_o;
          K_IRQ:   act = {15'b0, irq_o};
          K_ERR:   act = {15'b0, bus_err_o};
          default: act = {15'b0, spe_o};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(kind_e k, logic [15:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb_q.push_back(it);
    #0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [15:0] d, logic exp_err, string r);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    #1 push(K_ERR, {15'b0, exp_err}, r);
    step();
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(logic a, logic [15:0] e, string r);
    bus_addr_i = a;
    #1 push(K_RD, e, r);
  endtask

  task automatic chk_irq(logic e, string r);
    #1 push(K_IRQ, {15'b0, e}, r);
  endtask

  task automatic chk_spe(logic e, string r);
    #1 push(K_SPE, {15'b0, e}, r);
  endtask

  task automatic coll(logic exp_err, string r);
    collision_i = 1'b1;
    #1 push(K_ERR, {15'b0, exp_err}, r);
    step();
    collision_i = 1'b0;
  endtask

  task automatic done_at(logic [IDX_W-1:0] cur, logic [IDX_W-1:0] last);
    cur_idx_i = cur; end_ptr_i = last; cmd_done_i = 1'b1;
    step();
    cmd_done_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(1'b0, 16'h0000, "R1 ctl reset");
    rd(1'b1, 16'h0000, "R1 spe reset");
    chk_irq(1'b0, "R1 irq reset");
    #1 push(K_ERR, 16'h0, "R1 err reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    rd(1'b0, 16'h0000, "R1 ctl after release");

    // R2 layout, reserved bits zero
    wr(1'b0, 16'hFFFF, 1'b0, "R2 write all ones");
    rd(1'b0, 16'hDD00, "R2 readback layout");
    wr(1'b1, 16'hFFFF, 1'b0, "R2 spe write");
    rd(1'b1, 16'h0001, "R2 spe readback");
    wr(1'b0, 16'h0D00, 1'b0, "R2 irq enables only");

    // R10 collision sets flag, no error when disabled
    coll(1'b0, "R10 coll no err");
    rd(1'b0, 16'h0D08, "R10 coll flag");
    chk_irq(1'b1, "R4 irq coll");
    // R3 zero write keeps flag, one write clears
    wr(1'b0, 16'h0D00, 1'b0, "R3 w0");
    rd(1'b0, 16'h0D08, "R3 zero write no effect");
    wr(1'b0, 16'h0D08, 1'b0, "R3 w1");
    rd(1'b0, 16'h0D00, "R3 w1c clears");
    chk_irq(1'b0, "R4 irq cleared");

    // R4 masked flag does not interrupt
    wr(1'b0, 16'h0500, 1'b0, "R4 mask coll");
    coll(1'b0, "R4 coll masked");
    rd(1'b0, 16'h0508, "R4 flag set masked");
    chk_irq(1'b0, "R4 irq masked");

    // R11 set wins over clear
    bus_wr_i = 1'b1; bus_addr_i = 1'b0; bus_wdata_i = 16'h0508; collision_i = 1'b1;
    step();
    bus_wr_i = 1'b0; collision_i = 1'b0; bus_wdata_i = '0;
    rd(1'b0, 16'h0508, "R11 set wins");
    wr(1'b0, 16'h8D08, 1'b0, "R10 enable coll err");
    rd(1'b0, 16'h8D00, "R3 cleared");
    coll(1'b1, "R10 coll err");
    wr(1'b0, 16'h0D08, 1'b0, "R10 cleanup");
    rd(1'b0, 16'h0D00, "R10 cleanup read");

    // R7 end-pointer completion
    done_at(4'd3, 4'd5);
    rd(1'b0, 16'h0D00, "R7 non-end no flag");
    chk_spe(1'b1, "R7 non-end keeps spe");
    done_at(4'd5, 4'd5);
    rd(1'b0, 16'h0D01, "R7 end sets fin");
    chk_spe(1'b0, "R7 end clears spe");
    chk_irq(1'b1, "R4 irq fin");
    wr(1'b0, 16'h0D01, 1'b0, "R7 clr fin");
    done_at(4'd5, 4'd5);
    rd(1'b0, 16'h0D00, "R7 ignored when disabled");

    // R9 wraparound
    wr(1'b1, 16'h0001, 1'b0, "R9 spe on");
    wrap_en_i = 1'b1;
    done_at(4'd7, 4'd7);
    rd(1'b0, 16'h0D01, "R9 wrap sets fin");
    chk_spe(1'b1, "R9 wrap keeps spe");
    wrap_en_i = 1'b0;
    wr(1'b0, 16'h0D01, 1'b0, "R9 clr");

    // R8 halt at non-end index
    halt_req_i = 1'b1;
    done_at(4'd2, 4'd5);
    halt_req_i = 1'b0;
    rd(1'b0, 16'h0D01, "R8 halt sets fin");
    chk_spe(1'b0, "R8 halt clears spe");
    wr(1'b0, 16'h0D01, 1'b0, "R8 clr");

    // R5 abort without lock-out
    xfer_active_i = 1'b1;
    wr(1'b1, 16'h0001, 1'b0, "R5 spe on");
    wr(1'b1, 16'h0000, 1'b0, "R5 abort no err");
    chk_spe(1'b0, "R5 spe cleared");
    rd(1'b0, 16'h0D04, "R5 abort flag");
    chk_irq(1'b1, "R5 irq abort");
    wr(1'b0, 16'h4D04, 1'b0, "R5 aerr en");
    wr(1'b1, 16'h0001, 1'b0, "R5 spe on again");
    wr(1'b1, 16'h0000, 1'b1, "R5 abort with err");
    rd(1'b0, 16'h4D04, "R5 abort flag again");

    // R6 lock-out
    wr(1'b0, 16'h5D04, 1'b0, "R6 lock+aerr");
    wr(1'b1, 16'h0001, 1'b0, "R6 spe on");
    wr(1'b1, 16'h0000, 1'b1, "R6 blocked err");
    chk_spe(1'b1, "R6 spe held");
    rd(1'b0, 16'h5D00, "R6 no abort flag");
    wr(1'b0, 16'h1D00, 1'b0, "R6 lock only");
    wr(1'b1, 16'h0000, 1'b0, "R6 blocked no err");
    chk_spe(1'b1, "R6 spe held no err");
    done_at(4'd9, 4'd9);
    chk_spe(1'b0, "R6 completion clears spe");
    rd(1'b0, 16'h1D01, "R6 fin after completion");

    // R12 clear while idle
    xfer_active_i = 1'b0;
    wr(1'b0, 16'h0D01, 1'b0, "R12 unlock");
    wr(1'b1, 16'h0001, 1'b0, "R12 spe on");
    wr(1'b1, 16'h0000, 1'b0, "R12 idle clear no err");
    chk_spe(1'b0, "R12 spe off");
    rd(1'b0, 16'h0D00, "R12 no abort flag");

    step();
    wait (sb_q.size() == 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule